// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block is an 8-bit timer that counts up and then back down. It drives two compare channels, A and B, with symmetric dual-slope pulse-width modulation. The count advances only when a divided clock-enable fires. The divider setting picks a rate of the core clock divided by 1, 8, 64, 256 or 1024, or it stops the counter. One full up-and-down sweep takes 510 enable ticks, so the waveform repeats at fclk/(N*510).

Each channel has a two-bit output mode and a double-buffered compare value. A new compare value is written into a holding register and takes effect only when the count turns around at the top. Because of this, a running period is never cut short.

An overflow flag marks every return of the count to zero. A per-channel match flag marks every compare hit. All three flags are sticky and are cleared by write-one strobes.

Top module: `pcpwm_timer`

## Requirements
- R1: The count goes 0,1,...,255,254,...,1,0,1,... with one step per enable tick. The overflow flag becomes set on the tick that moves the count from 1 to 0, so consecutive sets are 510 ticks apart.
- R2: Divider select `clk_sel` encoding: 1 = every clock, 2 = every 8th, 3 = every 64th, 4 = every 256th, 5 = every 1024th clock. Values 0, 6 and 7 stop the count.
- R3: Mode 2 (non-inverting) applies when 0 < compare < 255. The output goes low on a hit while counting up and high on a hit while counting down. It is high for exactly 2*compare ticks of each 510-tick period.
- R4: Mode 3 is the inverse of mode 2: high for 510 - 2*compare ticks of each period.
- R5: In mode 2, a compare value of 0 keeps the output low for the whole period, and a value of 255 keeps it high for the whole period.
- R6: When the active compare value drops from 255 to 0, the mode-2 output falls on the tick that leaves the count value 0, with no up-count hit. The output is visible low one clock after the overflow flag appears at clk/1.
- R7: A compare write goes to a holding register. The holding register is copied to the active compare only on the tick at which the count is 255.
- R8: Mode 1 on channel A toggles the output on every hit, but only while `tgl_en` is 1. Mode 1 on channel A with `tgl_en` at 0, and mode 1 on channel B, leave the output unchanged.
- R9: Mode 0 leaves the output at its last value.
- R10: While the divider is stopped, the count, both outputs and the overflow flag do not change.
- R11: A channel's match flag sets on the tick at which the count equals its active compare value, and it stays set until its clear strobe. A set wins over a clear in the same cycle.
- R12: While `rst_n` is low, both outputs and all flags read 0. The count restarts at 0, counting up, with both active compare values at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| clk_sel | input | 3 | Divider select (R2 encoding) |
| tgl_en | input | 1 | Enables toggle mode on channel A |
| com_a | input | 2 | Channel A output mode |
| com_b | input | 2 | Channel B output mode |
| cmp_a_we | input | 1 | Write strobe for the channel A holding register |
| cmp_a_din | input | 8 | Channel A compare value to write |
| cmp_b_we | input | 1 | Write strobe for the channel B holding register |
| cmp_b_din | input | 8 | Channel B compare value to write |
| clr_ovf | input | 1 | Write-one clear of the overflow flag |
| clr_cm_a | input | 1 | Write-one clear of the channel A match flag |
| clr_cm_b | input | 1 | Write-one clear of the channel B match flag |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky overflow (bottom) flag |
| cm_a_flag | output | 1 | Sticky channel A match flag |
| cm_b_flag | output | 1 | Sticky channel B match flag |

## Verification
Every result is registered once after the enable tick that causes it. At clk/1, an event on the tick at clock edge k is visible at the falling edge that follows k. The overflow flag therefore serves as the time origin: a hit at count v in the up sweep shows on the flag or the output v+1 falling edges after the overflow flag is seen.

The duty sweep waits three overflow periods after each compare write. This covers the load at the top and one full settled period. It then counts high samples over exactly 510 falling edges. Divider rates are checked as the number of falling edges between two overflow sets.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  typedef enum logic [1:0] {
    OUT_HOLD   = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NORM   = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  typedef enum logic [2:0] {
    DIV_STOP  = 3'd0,
    DIV_1     = 3'd1,
    DIV_8     = 3'd2,
    DIV_64    = 3'd3,
    DIV_256   = 3'd4,
    DIV_1024  = 3'd5
  } div_sel_e;

  localparam int SH_8    = 3;
  localparam int SH_64   = 6;
  localparam int SH_256  = 8;
  localparam int SH_1024 = 10;

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
  import pcpwm_pkg::*;
#(
  parameter int DIV_W = SH_1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // a divided enable fires when the low bits of the free counter are all ones
  always_comb begin
    case (div_sel_e'(sel))
      DIV_1:    tick = 1'b1;
      DIV_8:    tick = &div_q[SH_8-1:0];
      DIV_64:   tick = &div_q[SH_64-1:0];
      DIV_256:  tick = &div_q[SH_256-1:0];
      DIV_1024: tick = &div_q[SH_1024-1:0];
      default:  tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         top_evt,
  output logic         bot_evt
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick) begin
      if (up_q) begin
        if (cnt_q == CMAX) begin
          cnt_d = CMAX - ONE;
          up_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = ONE;
          up_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt     = cnt_q;
  assign up      = up_q;
  assign top_evt = tick && up_q && (cnt_q == CMAX);
  assign bot_evt = tick && !up_q && (cnt_q == ONE);

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
  import pcpwm_pkg::*;
#(
  parameter int W          = 8,
  parameter bit HAS_TOGGLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic         top_evt,
  input  logic [1:0]   mode,
  input  logic         tgl_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         clr_flag,
  output logic [W-1:0] act_val,
  output logic         wave,
  output logic         flag
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] act_q, act_d;
  logic         wave_q, wave_d;
  logic         flag_q, flag_d;
  logic         hit;
  logic         lvl;
  logic         tgl_ok;

  // holding register and its transfer at the top of the sweep
  always_comb begin
    hold_d = wr_en ? wr_val : hold_q;
    act_d  = top_evt ? hold_q : act_q;
  end

  always_comb begin
    hit = tick && (cnt == act_q);
    // non-inverted level after a hit; extremes pin the level
    if (act_q == '0)        lvl = 1'b0;
    else if (act_q == CMAX) lvl = 1'b1;
    else                    lvl = ~up;
  end

  generate
    if (HAS_TOGGLE) begin : g_tgl
      assign tgl_ok = tgl_en;
    end else begin : g_no_tgl
      assign tgl_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    wave_d = wave_q;
    if (hit) begin
      case (out_mode_e'(mode))
        OUT_TOGGLE: if (tgl_ok) wave_d = ~wave_q;
        OUT_NORM:   wave_d = lvl;
        OUT_INV:    wave_d = ~lvl;
        default:    wave_d = wave_q;
      endcase
    end
  end

  always_comb begin
    if (hit)           flag_d = 1'b1;
    else if (clr_flag) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
      wave_q <= wave_d;
      flag_q <= flag_d;
    end
  end

  assign act_val = act_q;
  assign wave    = wave_q;
  assign flag    = flag_q;

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int W     = 8,
  parameter int NCH   = 2,
  parameter int DIV_W = SH_1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   clk_sel,
  input  logic         tgl_en,
  input  logic [1:0]   com_a,
  input  logic [1:0]   com_b,
  input  logic         cmp_a_we,
  input  logic [W-1:0] cmp_a_din,
  input  logic         cmp_b_we,
  input  logic [W-1:0] cmp_b_din,
  input  logic         clr_ovf,
  input  logic         clr_cm_a,
  input  logic         clr_cm_b,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf_flag,
  output logic         cm_a_flag,
  output logic         cm_b_flag
);

  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic         tick;
  logic [W-1:0] cnt;
  logic         up;
  logic         top_evt;
  logic         bot_evt;

  pcpwm_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_q),
    .sel   (clk_sel),
    .tick  (tick)
  );

  pcpwm_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q),
    .tick    (tick),
    .cnt     (cnt),
    .up      (up),
    .top_evt (top_evt),
    .bot_evt (bot_evt)
  );

  logic [NCH-1:0][1:0]   ch_mode;
  logic [NCH-1:0]        ch_we;
  logic [NCH-1:0][W-1:0] ch_din;
  logic [NCH-1:0]        ch_clr;
  logic [NCH-1:0][W-1:0] ch_act;
  logic [NCH-1:0]        ch_wave;
  logic [NCH-1:0]        ch_flag;

  assign ch_mode = {com_b, com_a};
  assign ch_we   = {cmp_b_we, cmp_a_we};
  assign ch_din  = {cmp_b_din, cmp_a_din};
  assign ch_clr  = {clr_cm_b, clr_cm_a};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      pcpwm_channel #(.W(W), .HAS_TOGGLE(i == 0)) u_ch (
        .clk      (clk),
        .rst_n    (rst_q),
        .tick     (tick),
        .cnt      (cnt),
        .up       (up),
        .top_evt  (top_evt),
        .mode     (ch_mode[i]),
        .tgl_en   (tgl_en),
        .wr_en    (ch_we[i]),
        .wr_val   (ch_din[i]),
        .clr_flag (ch_clr[i]),
        .act_val  (ch_act[i]),
        .wave     (ch_wave[i]),
        .flag     (ch_flag[i])
      );
    end
  endgenerate

  logic [W-1:0] act_a;
  assign act_a = ch_act[0];

  logic ovf_q, ovf_d;

  always_comb begin
    if (bot_evt)      ovf_d = 1'b1;
    else if (clr_ovf) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign wave_a    = ch_wave[0];
  assign wave_b    = ch_wave[1];
  assign cm_a_flag = ch_flag[0];
  assign cm_b_flag = ch_flag[1];
  assign ovf_flag  = ovf_q;

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic         up,
  input logic [2:0]   clk_sel,
  input logic [1:0]   com_a,
  input logic [1:0]   com_b,
  input logic [W-1:0] act_a,
  input logic         clr_cm_a,
  input logic         wave_a,
  input logic         wave_b,
  input logic         ovf_flag,
  input logic         cm_a_flag
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));

  p_step_dn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_ovf_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && cnt == 1) |=> ovf_flag);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |=> ($stable(cnt) && $stable(wave_a) && $stable(wave_b)));

  p_max_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == CMAX && act_a == CMAX && com_a == 2'd2) |=> wave_a);

  p_bot_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && act_a == '0 && com_a == 2'd2) |=> !wave_a);

  p_b_no_tgl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (com_b == 2'd1) |=> $stable(wave_b));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (com_a == 2'd0) |=> $stable(wave_a));

  p_flag_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_a_flag && !clr_cm_a) |=> cm_a_flag);

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .tick      (tick),
  .cnt       (cnt),
  .up        (up),
  .clk_sel   (clk_sel),
  .com_a     (com_a),
  .com_b     (com_b),
  .act_a     (act_a),
  .clr_cm_a  (clr_cm_a),
  .wave_a    (wave_a),
  .wave_b    (wave_b),
  .ovf_flag  (ovf_flag),
  .cm_a_flag (cm_a_flag)
);

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic       tgl_en;
  logic [1:0] com_a, com_b;
  logic       cmp_a_we, cmp_b_we;
  logic [7:0] cmp_a_din, cmp_b_din;
  logic       clr_ovf, clr_cm_a, clr_cm_b;
  logic       wave_a, wave_b, ovf_flag, cm_a_flag, cm_b_flag;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  pcpwm_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .tgl_en    (tgl_en),
    .com_a     (com_a),
    .com_b     (com_b),
    .cmp_a_we  (cmp_a_we),
    .cmp_a_din (cmp_a_din),
    .cmp_b_we  (cmp_b_we),
    .cmp_b_din (cmp_b_din),
    .clr_ovf   (clr_ovf),
    .clr_cm_a  (clr_cm_a),
    .clr_cm_b  (clr_cm_b),
    .wave_a    (wave_a),
    .wave_b    (wave_b),
    .ovf_flag  (ovf_flag),
    .cm_a_flag (cm_a_flag),
    .cm_b_flag (cm_b_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    clr_ovf  = 1'b0;
    clr_cm_a = 1'b0;
    clr_cm_b = 1'b0;
    cmp_a_we = 1'b0;
    cmp_b_we = 1'b0;
  endtask

  // returns at the falling edge where the overflow flag is first seen, with a clear queued
  task automatic wait_ovf();
    step();
    while (!ovf_flag) step();
    clr_ovf = 1'b1;
  endtask

  task automatic write_both(input int v);
    cmp_a_din = 8'(v);
    cmp_b_din = 8'(v);
    cmp_a_we  = 1'b1;
    cmp_b_we  = 1'b1;
  endtask

  task automatic settle();
    wait_ovf();
    wait_ovf();
    wait_ovf();
  endtask

  initial begin
    while (cyc < 195000) @(negedge clk);
    chk(1'b0, "watchdog", cyc, 195000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_sel = 3'd1; tgl_en = 1'b0;
    com_a = 2'd2; com_b = 2'd3;
    cmp_a_we = 1'b0; cmp_b_we = 1'b0; cmp_a_din = '0; cmp_b_din = '0;
    clr_ovf = 1'b0; clr_cm_a = 1'b0; clr_cm_b = 1'b0;
    repeat (3) @(negedge clk);

    // R12: reset state
    chk(!wave_a && !wave_b, "R12 waves", {wave_a, wave_b}, 0);
    chk(!ovf_flag && !cm_a_flag && !cm_b_flag, "R12 flags",
        {ovf_flag, cm_a_flag, cm_b_flag}, 0);
    rst_n = 1'b1;

    // R1: overflow spacing at clk/1
    begin
      int n;
      wait_ovf();
      n = 0;
      do begin step(); n++; end while (!ovf_flag);
      clr_ovf = 1'b1;
      chk(n == 510, "R1 bottom period", n, 510);
    end

    // R3/R4/R5: duty sweep, A non-inverting, B inverting
    begin
      int vals[$];
      for (int v = 0; v <= 252; v += 12) vals.push_back(v);
      vals.push_back(1); vals.push_back(254); vals.push_back(255);
      foreach (vals[k]) begin
        int v, ha, hb;
        v = vals[k];
        write_both(v);
        settle();
        ha = 0; hb = 0;
        for (int i = 0; i < 510; i++) begin
          step();
          if (wave_a) ha++;
          if (wave_b) hb++;
        end
        if (v == 0 || v == 255)
          chk(ha == 2 * v, "R5 extreme duty A", ha, 2 * v);
        else
          chk(ha == 2 * v, "R3 duty A", ha, 2 * v);
        chk(hb == 510 - 2 * v, "R4 duty B", hb, 510 - 2 * v);
      end
    end

    // R6: 255 to 0 gives a fall on leaving the bottom
    write_both(255);
    settle();
    write_both(0);
    wait_ovf();
    chk(wave_a == 1'b1, "R6 high at bottom", wave_a, 1);
    step();
    chk(wave_a == 1'b0, "R6 fall after bottom", wave_a, 0);

    // R7 and R3 timing: a write mid-period waits for the top
    write_both(200);
    settle();
    write_both(50);
    for (int i = 1; i <= 200; i++) begin
      step();
      if (i == 100) chk(wave_a == 1'b1, "R7 old compare still active", wave_a, 1);
      if (i == 200) chk(wave_a == 1'b1, "R3 before up hit", wave_a, 1);
    end
    step();
    chk(wave_a == 1'b0, "R3 clear at up hit", wave_a, 0);

    // R11: match flag timing and hold
    write_both(10);
    settle();
    clr_cm_a = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      step();
      if (i == 1)   chk(!cm_a_flag, "R11 cleared", cm_a_flag, 0);
      if (i == 10)  chk(!cm_a_flag, "R11 not before hit", cm_a_flag, 0);
      if (i == 11)  chk(cm_a_flag, "R11 set at hit", cm_a_flag, 1);
      if (i == 100) chk(cm_a_flag, "R11 held", cm_a_flag, 1);
    end

    // R8: toggle on A with enable, none on B
    write_both(100);
    com_a = 2'd1; com_b = 2'd1; tgl_en = 1'b1;
    settle();
    begin
      int ta, tb;
      logic pa, pb;
      ta = 0; tb = 0; pa = wave_a; pb = wave_b;
      for (int i = 0; i < 510; i++) begin
        step();
        if (wave_a != pa) ta++;
        if (wave_b != pb) tb++;
        pa = wave_a; pb = wave_b;
      end
      chk(ta == 2, "R8 A toggles", ta, 2);
      chk(tb == 0, "R8 B no toggle", tb, 0);
      tgl_en = 1'b0;
      ta = 0;
      for (int i = 0; i < 510; i++) begin
        step();
        if (wave_a != pa) ta++;
        pa = wave_a;
      end
      chk(ta == 0, "R8 A toggle disabled", ta, 0);
    end

    // R9: mode 0 holds
    com_a = 2'd2; com_b = 2'd3;
    settle();
    com_a = 2'd0;
    begin
      int ta;
      logic pa;
      ta = 0; pa = wave_a;
      for (int i = 0; i < 1020; i++) begin
        step();
        if (wave_a != pa) ta++;
        pa = wave_a;
      end
      chk(ta == 0, "R9 hold", ta, 0);
    end

    // R10: stopped divider
    com_a = 2'd2;
    wait_ovf();
    step();
    clk_sel = 3'd0;
    begin
      int ch;
      logic pa, pb;
      ch = 0; pa = wave_a; pb = wave_b;
      for (int i = 0; i < 1200; i++) begin
        step();
        if (wave_a != pa || wave_b != pb || ovf_flag) ch++;
        pa = wave_a; pb = wave_b;
      end
      chk(ch == 0, "R10 frozen", ch, 0);
    end

    // R2: unused select code also stops, then divided rates
    clk_sel = 3'd6;
    begin
      int ch;
      ch = 0;
      for (int i = 0; i < 600; i++) begin
        step();
        if (ovf_flag) ch++;
      end
      chk(ch == 0, "R2 code 6 stopped", ch, 0);
    end
    clk_sel = 3'd2;
    begin
      int n;
      wait_ovf();
      n = 0;
      do begin step(); n++; end while (!ovf_flag);
      clr_ovf = 1'b1;
      chk(n == 4080, "R2 divide by 8", n, 4080);
    end
    clk_sel = 3'd3;
    begin
      int n;
      wait_ovf();
      n = 0;
      do begin step(); n++; end while (!ovf_flag);
      clr_ovf = 1'b1;
      chk(n == 32640, "R2 divide by 64", n, 32640);
    end

    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule